// File: doc/BRIEF.md
# Speaker and Refresh Control Port

This block is a single-address byte register that sits beside a three-channel interval timer. It controls the gate input of the timer channel that drives the speaker, and it holds an enable flag for the speaker data. A read returns a status byte with four live bits. Two of them are the gate and the enable flag as last written. The third is the current output of the speaker channel. The fourth is a refresh toggle that runs freely and flips at roughly 15 µs intervals.

The refresh toggle comes from a nanosecond accumulator. The accumulator adds the clock period in nanoseconds on every cycle, and the toggle is bit 14 of that count. It therefore changes state once every 16384 ns.

The speaker output is the speaker channel's output qualified by the enable flag. The block also supplies the gate inputs of the other timer channels, which are held high. When a write raises the speaker channel's gate, the block sends a single-cycle edge event to that channel so that its retriggerable modes restart.

Top module: `spk_port`

## Requirements
- R1: Reset is synchronous and active low. While it is asserted, the speaker channel gate and the data-enable flag clear to 0, the gates of all other channels are 1, and the nanosecond count clears to 0.
- R2: A write (`port_wr` high at a rising clock edge) loads bit 0 of `port_wdata` into the speaker channel gate. The new value appears on `ch_gate[SPK_CH]` after that edge.
- R3: A write loads bit 1 of `port_wdata` into the data-enable flag. The new value is visible in `port_rdata` bit 1 after that edge.
- R4: The read byte places the bits as follows: bit 0 is the speaker channel gate, bit 1 is the data-enable flag, bit 4 is the refresh toggle and bit 5 is `ch2_out`. Bits 2, 3, 6 and 7 read 0.
- R5: The nanosecond count advances by `CLK_PERIOD_NS` on each clock edge out of reset. The refresh toggle equals bit `REFRESH_BIT` (default 14) of the count. After N edges out of reset the toggle therefore equals bit 14 of N*20.
- R6: `spkr_out` equals `ch2_out` AND the data-enable flag, combinationally.
- R7: `gate_rise` is high for exactly the one cycle after a write that changes the speaker channel gate from 0 to 1. It stays low when a written 1 finds the gate already at 1, and it stays low when the gate falls.
- R8: Bits 7 to 2 of a written byte have no effect on the gate, the enable flag or the read byte.
- R9: Without a write, the gate and the enable flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_wr | input | 1 | Write strobe for the control byte |
| port_wdata | input | 8 | Write data; only bits 1:0 are used |
| ch2_out | input | 1 | Output of the speaker timer channel |
| port_rdata | output | 8 | Status byte, valid at all times |
| ch_gate | output | NUM_CH | Gate inputs of the timer channels |
| gate_rise | output | 1 | One-cycle pulse when a write raises the speaker gate |
| spkr_out | output | 1 | Speaker signal: channel output AND enable |

## Verification
The main stimulus is random write bytes with random `ch2_out` values. Because all eight data bits are random, this shows that only bits 1:0 matter and keeps the gate and the enable flag apart. Runs of repeated gate-high writes separate a true 0-to-1 edge from a write that leaves the gate at 1, and so check the single-pulse rule. The run lasts several thousand cycles, which covers multiple refresh periods, and the bench compares the toggle with bit 14 of the elapsed nanoseconds on every cycle. Directed writes of 0xFC, 0xFF and a double 0x01 cover the ignored upper bits and the case where a write does not raise the gate.

// File: rtl/spk_pkg.sv
// Package: shared field positions and types for the speaker control port.
// Assumes a byte-wide port; positions are fixed by software convention.
package spk_pkg;
    localparam int RD_GATE_BIT = 0;
    localparam int RD_EN_BIT   = 1;
    localparam int RD_REF_BIT  = 4;
    localparam int RD_OUT_BIT  = 5;
    localparam int WR_GATE_BIT = 0;
    localparam int WR_EN_BIT   = 1;

    typedef struct packed {
        logic data_en;
        logic gate;
    } spk_ctl_t;
endpackage

// File: rtl/spk_ctl_reg.sv
// Control register: holds the speaker gate and data-enable flag and
// produces a one-cycle pulse when a write raises the gate.
// Assumes the write strobe is synchronous to clk.
module spk_ctl_reg
    import spk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  logic     wr_gate,
    input  logic     wr_en,
    output spk_ctl_t ctl,
    output logic     rise
);
    // Register update and edge detection on the written gate value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl  <= '0;
            rise <= 1'b0;
        end else begin
            rise <= wr && wr_gate && !ctl.gate;
            if (wr) begin
                ctl.gate    <= wr_gate;
                ctl.data_en <= wr_en;
            end
        end
    end
endmodule

// File: rtl/spk_refresh_gen.sv
// Refresh toggle generator: a nanosecond accumulator advanced by the
// clock period each cycle; the toggle is one selected bit of it.
// Assumes CLK_PERIOD_NS is smaller than 2**REFRESH_BIT.
module spk_refresh_gen #(
    parameter int CLK_PERIOD_NS = 20,
    parameter int REFRESH_BIT   = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic refresh
);
    localparam int NS_W = REFRESH_BIT + 1;
    localparam logic [NS_W-1:0] STEP = NS_W'(CLK_PERIOD_NS);

    logic [NS_W-1:0] ns_cnt;

    // Accumulate elapsed nanoseconds, wrapping above the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ns_cnt <= '0;
        else        ns_cnt <= ns_cnt + STEP;
    end

    assign refresh = ns_cnt[REFRESH_BIT];
endmodule

// File: rtl/spk_readback.sv
// Read mux: merges control bits, channel output and refresh toggle into
// the status byte; unused positions read zero.
module spk_readback
    import spk_pkg::*;
#(
    parameter int DW = 8
) (
    input  spk_ctl_t      ctl,
    input  logic          chan_out,
    input  logic          refresh,
    output logic [DW-1:0] rdata
);
    // Build the status byte from its live sources.
    always_comb begin
        rdata              = '0;
        rdata[RD_GATE_BIT] = ctl.gate;
        rdata[RD_EN_BIT]   = ctl.data_en;
        rdata[RD_REF_BIT]  = refresh;
        rdata[RD_OUT_BIT]  = chan_out;
    end
endmodule

// File: rtl/spk_port.sv
// Top: speaker and refresh control port next to a multi-channel timer.
// Drives the gates of all channels (non-speaker ones held high), the
// speaker signal, and a retrigger pulse for the speaker channel.
// Assumes a single clock domain and synchronous active-low reset.
module spk_port
    import spk_pkg::*;
#(
    parameter int DW            = 8,
    parameter int NUM_CH        = 3,
    parameter int SPK_CH        = 2,
    parameter int CLK_PERIOD_NS = 20,
    parameter int REFRESH_BIT   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [DW-1:0]     port_wdata,
    input  logic              ch2_out,
    output logic [DW-1:0]     port_rdata,
    output logic [NUM_CH-1:0] ch_gate,
    output logic              gate_rise,
    output logic              spkr_out
);
    spk_ctl_t ctl;
    logic     refresh;
    logic     wdata_unused;

    assign wdata_unused = ^port_wdata;

    spk_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (port_wr),
        .wr_gate (port_wdata[WR_GATE_BIT]),
        .wr_en   (port_wdata[WR_EN_BIT]),
        .ctl     (ctl),
        .rise    (gate_rise)
    );

    spk_refresh_gen #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .REFRESH_BIT   (REFRESH_BIT)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh)
    );

    spk_readback #(.DW(DW)) u_rb (
        .ctl      (ctl),
        .chan_out (ch2_out),
        .refresh  (refresh),
        .rdata    (port_rdata)
    );

    // Gate fan-out: speaker channel from the register, others held high.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
        if (g == SPK_CH) begin : g_spk
            assign ch_gate[g] = ctl.gate;
        end else begin : g_fixed
            assign ch_gate[g] = 1'b1;
        end
    end

    // Speaker signal qualified by the data-enable flag.
    assign spkr_out = ch2_out & ctl.data_en;
endmodule

// File: rtl/spk_port_chk.sv
// Checker for spk_port: port-level temporal properties, bound to the top.
module spk_port_chk #(
    parameter int DW     = 8,
    parameter int NUM_CH = 3,
    parameter int SPK_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_wr,
    input logic [DW-1:0]     port_wdata,
    input logic              ch2_out,
    input logic [DW-1:0]     port_rdata,
    input logic [NUM_CH-1:0] ch_gate,
    input logic              gate_rise,
    input logic              spkr_out
);
    a_r2_gate_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> ch_gate[SPK_CH] == $past(port_wdata[0]));

    a_r3_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> port_rdata[1] == $past(port_wdata[1]));

    a_r4_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        port_rdata[7:6] == 2'b00 && port_rdata[3:2] == 2'b00);

    a_r4_gate_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        port_rdata[0] == ch_gate[SPK_CH]);

    a_r6_speaker: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_out == (ch2_out && port_rdata[1]));

    a_r7_rise_real_edge: assert property (@(posedge clk) disable iff (!rst_n)
        gate_rise |-> ch_gate[SPK_CH] && !$past(ch_gate[SPK_CH]));

    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        gate_rise |=> !gate_rise);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(ch_gate[SPK_CH]) && $stable(port_rdata[1]));
endmodule

bind spk_port spk_port_chk #(.DW(DW), .NUM_CH(NUM_CH), .SPK_CH(SPK_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .ch2_out    (ch2_out),
    .port_rdata (port_rdata),
    .ch_gate    (ch_gate),
    .gate_rise  (gate_rise),
    .spkr_out   (spkr_out)
);

// File: tb/spk_port_tb.sv
// Bench for spk_port: seeded random writes and channel outputs plus
// directed corners, compared against a reference model held in the bench.
module spk_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = '0;
    logic       ch2_out = 1'b0;
    logic [7:0] port_rdata;
    logic [2:0] ch_gate;
    logic       gate_rise;
    logic       spkr_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    longint cyc = 0;
    bit  m_gate = 0, m_en = 0, m_rise = 0;

    always #10 clk = ~clk;

    spk_port u_dut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
        .ch2_out(ch2_out), .port_rdata(port_rdata), .ch_gate(ch_gate),
        .gate_rise(gate_rise), .spkr_out(spkr_out)
    );

    // Count clock edges since reset release, as the elapsed-time reference.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic bit exp_refresh(longint n);
        return bit'(((n * 20) >> 14) & 1);
    endfunction

    function automatic logic [7:0] exp_rdata(bit g, bit e, bit r, bit o);
        return {2'b00, o, r, 2'b00, e, g};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Apply one cycle of stimulus at negedge, check, then advance the model.
    task automatic step(bit wr, logic [7:0] d, bit o);
        @(negedge clk);
        port_wr = wr; port_wdata = d; ch2_out = o;
        #1;
        chk("R4 read byte (R5 refresh)", port_rdata,
            exp_rdata(m_gate, m_en, exp_refresh(cyc), o));
        chk("R2/R9 gate", {7'd0, ch_gate[2]}, {7'd0, m_gate});
        chk("R6 speaker", {7'd0, spkr_out}, {7'd0, o & m_en});
        chk("R7 rise pulse", {7'd0, gate_rise}, {7'd0, m_rise});
        @(posedge clk);
        m_rise = wr && d[0] && !m_gate;
        if (wr) begin m_gate = d[0]; m_en = d[1]; end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset gates", {5'd0, ch_gate}, 8'b0000_0011);
        chk("R1 reset read", port_rdata, 8'h00);
        rst_n = 1'b1;
        // R8: upper bits only, nothing changes
        step(1, 8'hFC, 1);
        step(0, 8'h00, 1);
        // R7: raise, then rewrite 1 without a second pulse
        step(1, 8'h01, 0);
        step(1, 8'h01, 1);
        step(0, 8'h00, 1);
        // R3/R6: all bits set, speaker follows channel output
        step(1, 8'hFF, 1);
        step(0, 8'h55, 0);
        step(0, 8'hAA, 1);
        // R7: falling gate gives no pulse
        step(1, 8'h02, 1);
        step(0, 8'h00, 0);
        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom % 4) == 0;
            step(w, 8'($urandom), 1'($urandom));
        end
        chk("R1 other gates held", {6'd0, ch_gate[1:0]}, 8'h03);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule